// File: doc/BRIEF.md
# Inter-Processor Interrupt Generation Register Bank

This block holds one 32-bit doorbell register per target core, eight by default, on a simple register bus made of an address, a write enable, write data and combinational read data. When a sender writes a register with bit 0 set, the matching core receives a one-cycle event pulse. Bits 31:4 of the same write are kept in the register as sticky source flags. The receiving core can read these flags to learn which sender raised the interrupt. The core then clears the flags it has handled by writing 1s to a separate acknowledge register for its channel.

Each channel runs a two-state machine. The machine stays in CH_IDLE until a trigger write arrives, which means a write to its doorbell with bit 0 equal to 1. That write moves it to CH_PULSE, and the event output is high for the whole of this state. From CH_PULSE a further trigger write keeps it in CH_PULSE. Any other cycle returns it to CH_IDLE. The source flags sit beside the state machine. A doorbell write ORs new flags in, and an acknowledge write clears the flags written as 1.

Doorbell `i` is at byte address 0x240 + 4*i and its acknowledge register is at 0x280 + 4*i. Both addresses read back the same value: the flags in bits 31:4, with bits 3:0 reading as zero.

Top module: `ipc_gen_bank`

## Requirements
- R1: After reset every doorbell and acknowledge address reads 0 and no event output is high.
- R2: A write to doorbell i (address 0x240 + 4*i) with bit 0 equal to 1 drives core_event[i] high for exactly the one cycle after the write edge, and leaves every other event bit low.
- R3: Bit 0 and the reserved bits 3:1 always read as 0. For example, writing 0x11 to an empty doorbell reads back as 0x10.
- R4: In a doorbell write, each 1 in bits 31:4 sets that source flag and each 0 leaves that flag unchanged.
- R5: A doorbell write with bit 0 equal to 0 raises no event but still sets the flag bits it carries.
- R6: A write to acknowledge register i (address 0x280 + 4*i) clears each flag of channel i written as 1, leaves the others unchanged, and raises no event.
- R7: Reading acknowledge register i returns the same value as reading doorbell i.
- R8: A write to any address other than the sixteen mapped words, misaligned addresses included, changes no flag and raises no event, and such an address reads 0.
- R9: A write to one channel leaves the flags of every other channel unchanged.
- R10: Trigger writes to the same doorbell on consecutive cycles keep its event high on consecutive cycles, one cycle per write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write enable, one write per high cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| core_event | output | 8 | Event pulse, one bit per target core |

## Verification
Flag updates and event pulses are both registered on the write edge. Each is therefore due in the cycle that starts at that edge, and the event falls one edge later unless another trigger write follows. Read data is combinational on the address, so a read shows the flags as they stand once the last write edge has passed. The bench changes its inputs on the falling edge. It samples the event half a cycle after the write edge, checks again one cycle later that the pulse has ended, and reads the registers after a short settle delay that contains no rising edge.

// File: rtl/ipc_gen_pkg.sv
package ipc_gen_pkg;

    // Position of the self-clearing trigger bit and first flag bit
    localparam int TRIG_BIT = 0;
    localparam int FLAG_LSB = 4;

    typedef enum logic {
        CH_IDLE  = 1'b0,
        CH_PULSE = 1'b1
    } ch_state_e;

endpackage

// File: rtl/ipc_addr_decode.sv
module ipc_addr_decode #(
    parameter int                NUM_CORES = 8,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] GEN_BASE  = 12'h240,
    parameter logic [ADDR_W-1:0] ACK_BASE  = 12'h280,
    localparam int               IDX_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_CORES-1:0] gen_hit,
    output logic [NUM_CORES-1:0] ack_hit,
    output logic                 any_hit,
    output logic [IDX_W-1:0]     hit_idx
);

    // Exact word match per channel; misaligned addresses never match
    for (genvar i = 0; i < NUM_CORES; i++) begin : g_match
        localparam logic [ADDR_W-1:0] GEN_ADDR = GEN_BASE + ADDR_W'(4 * i);
        localparam logic [ADDR_W-1:0] ACK_ADDR = ACK_BASE + ADDR_W'(4 * i);
        assign gen_hit[i] = (addr == GEN_ADDR);
        assign ack_hit[i] = (addr == ACK_ADDR);
    end

    always_comb begin
        any_hit = |{gen_hit, ack_hit};
        hit_idx = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            if (gen_hit[i] || ack_hit[i]) begin
                hit_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/ipc_gen_channel.sv
module ipc_gen_channel
    import ipc_gen_pkg::*;
#(
    parameter int FLAG_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gen_we,
    input  logic              ack_we,
    input  logic              wr_trig,
    input  logic [FLAG_W-1:0] wr_flags,
    output logic [FLAG_W-1:0] flags,
    output logic              event_o
);

    ch_state_e state_q;
    ch_state_e state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE:  state_d = (gen_we && wr_trig) ? CH_PULSE : CH_IDLE;
            CH_PULSE: state_d = (gen_we && wr_trig) ? CH_PULSE : CH_IDLE;
            default:  state_d = CH_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        event_o = 1'b0;
        unique case (state_q)
            CH_IDLE:  event_o = 1'b0;
            CH_PULSE: event_o = 1'b1;
            default:  event_o = 1'b0;
        endcase
    end

    // Sticky source flags: set by doorbell writes, cleared by acknowledge writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (gen_we) begin
            flags <= flags | wr_flags;
        end else if (ack_we) begin
            flags <= flags & ~wr_flags;
        end
    end

endmodule

// File: rtl/ipc_gen_bank.sv
module ipc_gen_bank
    import ipc_gen_pkg::*;
#(
    parameter int         NUM_CORES = 8,
    parameter int         DATA_W    = 32,
    parameter int         ADDR_W    = 12,
    parameter logic [11:0] GEN_BASE = 12'h240,
    parameter logic [11:0] ACK_BASE = 12'h280
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_CORES-1:0] core_event
);

    localparam int FLAG_W = DATA_W - FLAG_LSB;
    localparam int IDX_W  = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

    logic [NUM_CORES-1:0]        gen_hit;
    logic [NUM_CORES-1:0]        ack_hit;
    logic                        any_hit;
    logic [IDX_W-1:0]            hit_idx;
    logic [FLAG_W-1:0]           flags_arr [NUM_CORES];
    logic [NUM_CORES*FLAG_W-1:0] flags_flat;
    logic                        unused_rsvd;

    assign unused_rsvd = ^bus_wdata[FLAG_LSB-1:TRIG_BIT+1];

    ipc_addr_decode #(
        .NUM_CORES (NUM_CORES),
        .ADDR_W    (ADDR_W),
        .GEN_BASE  (ADDR_W'(GEN_BASE)),
        .ACK_BASE  (ADDR_W'(ACK_BASE))
    ) u_decode (
        .addr    (bus_addr),
        .gen_hit (gen_hit),
        .ack_hit (ack_hit),
        .any_hit (any_hit),
        .hit_idx (hit_idx)
    );

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_chan
        ipc_gen_channel #(
            .FLAG_W (FLAG_W)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .gen_we   (bus_we && gen_hit[i]),
            .ack_we   (bus_we && ack_hit[i]),
            .wr_trig  (bus_wdata[TRIG_BIT]),
            .wr_flags (bus_wdata[DATA_W-1:FLAG_LSB]),
            .flags    (flags_arr[i]),
            .event_o  (core_event[i])
        );
        assign flags_flat[i*FLAG_W +: FLAG_W] = flags_arr[i];
    end

    // Both views of a channel return its flags; low nibble is always zero
    always_comb begin
        bus_rdata = '0;
        if (any_hit) begin
            bus_rdata = {flags_arr[hit_idx], {FLAG_LSB{1'b0}}};
        end
    end

endmodule

// File: rtl/ipc_gen_bank_chk.sv
module ipc_gen_bank_chk #(
    parameter int NUM_CORES = 8,
    parameter int DATA_W    = 32,
    parameter int FLAG_W    = 28
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_we,
    input logic [DATA_W-1:0]           bus_rdata,
    input logic [NUM_CORES-1:0]        core_event,
    input logic [NUM_CORES*FLAG_W-1:0] flags_flat
);

    // R2
    event_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(core_event));

    // R2
    event_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> (core_event == '0));

    // R3
    low_nibble_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[3:0] == 4'h0);

    // R8
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(flags_flat));

endmodule

bind ipc_gen_bank ipc_gen_bank_chk #(
    .NUM_CORES (NUM_CORES),
    .DATA_W    (DATA_W),
    .FLAG_W    (FLAG_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_rdata  (bus_rdata),
    .core_event (core_event),
    .flags_flat (flags_flat)
);

// File: tb/ipc_gen_bank_tb.sv
`timescale 1ns/1ps
module ipc_gen_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  core_event;

    int checks = 0;
    int fails  = 0;
    logic [27:0] exp_flag [8];

    always #2 clk = ~clk;

    ipc_gen_bank u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .core_event (core_event)
    );

    function automatic logic [11:0] gen_a(int i);
        return 12'h240 + 12'(4 * i);
    endfunction

    function automatic logic [11:0] ack_a(int i);
        return 12'h280 + 12'(4 * i);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Single-cycle write; returns at the falling edge after the write edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_addr  = 12'h000;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic check_all(input string req);
        logic [31:0] v;
        for (int k = 0; k < 8; k++) begin
            rd(gen_a(k), v);
            chk(req, v, {exp_flag[k], 4'h0});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [27:0] pat;
        for (int k = 0; k < 8; k++) exp_flag[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 event", {24'h0, core_event}, 32'h0);
        for (int k = 0; k < 8; k++) begin
            rd(gen_a(k), v); chk("R1 gen", v, 32'h0);
            rd(ack_a(k), v); chk("R1 ack", v, 32'h0);
        end

        for (int i = 0; i < 8; i++) begin
            pat = 28'((32'h9E3779B9 * (i + 1)) >> 3);
            // R2 / R3: trigger plus flags, reserved bits written as 1
            wr(gen_a(i), {pat, 4'hF});
            chk("R2 pulse", {24'h0, core_event}, 32'(1 << i));
            @(negedge clk);
            chk("R2 pulse end", {24'h0, core_event}, 32'h0);
            exp_flag[i] |= pat;
            rd(gen_a(i), v); chk("R3 R4 readback", v, {exp_flag[i], 4'h0});
            rd(ack_a(i), v); chk("R7 ack view", v, {exp_flag[i], 4'h0});
            // R5: no trigger, flags still set
            wr(gen_a(i), {~pat, 4'h0});
            chk("R5 no event", {24'h0, core_event}, 32'h0);
            exp_flag[i] |= ~pat;
            rd(gen_a(i), v); chk("R5 flags set", v, {exp_flag[i], 4'h0});
            // R6: acknowledge clears written ones only
            wr(ack_a(i), {pat, 4'hF});
            chk("R6 no event", {24'h0, core_event}, 32'h0);
            exp_flag[i] &= ~pat;
            rd(gen_a(i), v); chk("R6 cleared", v, {exp_flag[i], 4'h0});
            // R4: zero write leaves flags unchanged
            wr(gen_a(i), 32'h0);
            rd(gen_a(i), v); chk("R4 zero write", v, {exp_flag[i], 4'h0});
            rd(ack_a(i), v); chk("R7 ack view", v, {exp_flag[i], 4'h0});
        end
        // R9: channels isolated
        check_all("R9 isolation");

        // R8: unmapped and misaligned addresses
        begin
            logic [11:0] bad [6] = '{12'h23C, 12'h242, 12'h260, 12'h2A0, 12'h000, 12'h281};
            for (int b = 0; b < 6; b++) begin
                wr(bad[b], 32'hFFFF_FFFF);
                chk("R8 no event", {24'h0, core_event}, 32'h0);
                rd(bad[b], v); chk("R8 reads zero", v, 32'h0);
            end
        end
        check_all("R8 flags unchanged");

        // R10: back-to-back trigger writes on core 3
        @(negedge clk);
        bus_addr = gen_a(3); bus_wdata = 32'h0000_0011; bus_we = 1'b1;
        @(negedge clk);
        chk("R10 first pulse", {24'h0, core_event}, 32'h08);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 12'h000;
        chk("R10 second pulse", {24'h0, core_event}, 32'h08);
        @(negedge clk);
        chk("R10 pulse end", {24'h0, core_event}, 32'h0);
        exp_flag[3] |= 28'h1;
        rd(gen_a(3), v); chk("R3 0x11 reads 0x10 bits", v, {exp_flag[3], 4'h0});

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule